// File: doc/BRIEF.md
# AAL5 Frame Receive Reassembler

This block takes a stream of 14-word ATM cells for a single virtual circuit and rebuilds the AAL5 frames they carry. The cells arrive already validated. Each frame goes to an application over a word-wide frame interface. The start-of-cell strobe of the input is replaced by three output strobes: start of frame, end of frame and data enable. Data enable marks only real payload words, so padding never reaches the application. End of frame sits on the last real payload word. The two 32-bit trailer words follow it directly and are marked by a separate trailer strobe.

Where end of frame falls is only known once the trailer length has arrived, so payload words are written into a ring store as cells arrive. A frame descriptor is queued only when the final cell has passed the checks. The block runs a CRC-32 over the frame and checks the trailer length against the number of cells received. It also limits the number of cells in a frame. A frame that fails any of these checks is discarded, its ring space is taken back, and a one-cycle error pulse reports the cause. A frame that completes while an earlier one is still being delivered waits in the descriptor queue and follows it without a gap.

Top module: `aal5_rx_decap`

## Requirements
- R1: While reset is held, and after reset until the first frame completes, out_de, out_sof, out_eof, out_trl and err_vld are all low.
- R2: A good frame of L payload octets is delivered as ceil(L/4) consecutive words with out_de high, in arrival order and big-endian octet packing. The first of these words carries out_sof. Padding words are never presented with out_de high.
- R3: out_eof is high on exactly one word per frame: payload word ceil(L/4)-1, which also has out_de high.
- R4: Directly after the out_eof word come exactly two words with out_trl high and out_de low. The first is {control[31:16], length[15:0]} and the second is the received CRC word.
- R5: Each cell is 14 words long, and in_soc marks word 0. Words 0 and 1 are header and words 2 to 13 are payload. Bit 1 of header word 0 set to 1 marks the last cell of a frame.
- R6: The CRC-32 uses polynomial 0x04C11DB7 and starts at all ones. It is fed MSB first over every payload word of the frame except the last one. If its complement differs from the last word, the frame is dropped with err_code 1.
- R7: A frame is dropped with err_code 2 if its length field is 0, or if L+8 does not fall in the range ((n-1)*48, n*48] for n received cells. This check takes priority over the CRC check.
- R8: A frame with more than MAX_CELLS cells is dropped with err_code 3 when its last cell ends. This check takes priority over all others. The next frame is handled normally.
- R9: err_vld pulses for one cycle right after the clock edge that samples the final cell word. For a good frame, the word carrying out_sof appears one edge later.
- R10: If a frame completes while another is being delivered, it is queued. Its out_sof word follows the earlier frame's second trailer word in the very next cycle.
- R11: Cycles with in_vld low are ignored, so gaps between input words do not change the delivered frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input word valid |
| in_soc | input | 1 | Input word is word 0 of a cell |
| in_data | input | 32 | Input cell word |
| out_data | output | 32 | Output frame word |
| out_de | output | 1 | Output word is real payload |
| out_sof | output | 1 | First payload word of a frame |
| out_eof | output | 1 | Last payload word of a frame |
| out_trl | output | 1 | Output word is one of the two trailer words |
| err_vld | output | 1 | One-cycle pulse: a frame was dropped |
| err_code | output | 2 | Drop cause: 1 CRC, 2 length, 3 too many cells |

## Verification
Some output properties are checked by assertions on every cycle. End of frame always coincides with data enable, a trailer word always follows end of frame, and data enable never resumes inside a frame without a start of frame. The same assertions check that a dropped frame always returns its ring space, that the descriptor queue is never pushed when full or popped when empty, and that an error pulse lasts one cycle. Word contents, padding removal, the CRC and length verdicts, the cell-count limit, exact latencies and back-to-back queuing can only be shown by the directed scenarios. These compare the delivered words against frames built and checksummed independently by the bench.

// File: rtl/aal5_rx_pkg.sv
package aal5_rx_pkg;

  localparam int          CELL_WORDS = 14;
  localparam int          HDR_WORDS  = 2;
  localparam int          PAY_WORDS  = CELL_WORDS - HDR_WORDS;
  localparam int          CELL_OCTS  = PAY_WORDS * 4;
  localparam int          TRL_OCTS   = 8;
  localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CRC  = 2'd1,
    ERR_LEN  = 2'd2,
    ERR_LONG = 2'd3
  } err_t;

  // one accepted frame waiting for delivery
  typedef struct packed {
    logic [15:0] base;    // ring address of first payload word
    logic [15:0] nwords;  // real payload words
    logic [15:0] tail;    // offset of first trailer word from base
  } fdesc_t;

  // advance the CRC by one 32-bit word, most significant bit first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ w[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/aal5_rx_ring.sv
module aal5_rx_ring
  import aal5_rx_pkg::*;
#(
  parameter int WORDS = 192,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);

  logic [31:0] store_q [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
  end

  assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/aal5_rx_dfifo.sv
module aal5_rx_dfifo
  import aal5_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  fdesc_t din,
  input  logic   pop,
  output fdesc_t dout,
  output logic   empty,
  output logic   full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  fdesc_t        slot_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = slot_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_wr) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_rd) rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_wr && !do_rd)      cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) slot_q[wr_q] <= din;
  end

  // R10
  // no_overflow_chk
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);

  // R10
  // no_underflow_chk
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/aal5_rx_ingest.sv
module aal5_rx_ingest
  import aal5_rx_pkg::*;
#(
  parameter int MAX_CELLS  = 8,
  parameter int RING_WORDS = 192,
  parameter int AW         = 8,
  parameter int LAST_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_soc,
  input  logic [31:0]   in_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          push,
  output fdesc_t        push_desc,
  output logic          err_vld,
  output logic [1:0]    err_code
);

  localparam int IW = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1;

  logic [3:0]    wpos_q, wpos_d, cur;
  logic          act_q, act_d;
  logic          last_q, last_d;
  logic          ovf_q, ovf_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [31:0]   crc_q, crc_d;
  logic [15:0]   len_q, len_d;
  logic [AW-1:0] wptr_q, wptr_d, wptr_inc;
  logic [AW-1:0] fbase_q, fbase_d;
  logic          errv_q, errv_d;
  err_t          errc_q, errc_d;

  logic          is_pay, is_final;
  logic [19:0]   ncell, tot, hi_lim, lo_lim;
  logic          len_ok, crc_ok;
  err_t          verdict;

  assign cur      = in_soc ? 4'd0 : wpos_q;
  assign is_pay   = (cur >= 4'(HDR_WORDS));
  assign is_final = last_q && (cur == 4'(CELL_WORDS - 1));
  assign wptr_inc = (wptr_q == AW'(RING_WORDS - 1)) ? '0 : wptr_q + 1'b1;

  // length and CRC verdict for the final word of the last cell
  assign ncell  = 20'(idx_q) + 20'd1;
  assign tot    = {4'd0, len_q} + 20'(TRL_OCTS);
  assign hi_lim = ncell * 20'(CELL_OCTS);
  assign lo_lim = (ncell - 20'd1) * 20'(CELL_OCTS);
  assign len_ok = (len_q != 16'd0) && (tot <= hi_lim) && (tot > lo_lim);
  assign crc_ok = (in_data == ~crc_q);

  always_comb begin
    if (ovf_q)        verdict = ERR_LONG;
    else if (!len_ok) verdict = ERR_LEN;
    else if (!crc_ok) verdict = ERR_CRC;
    else              verdict = ERR_NONE;
  end

  assign wr_en   = in_vld && is_pay && !ovf_q;
  assign wr_addr = wptr_q;
  assign wr_data = in_data;

  assign push             = in_vld && is_final && (verdict == ERR_NONE);
  assign push_desc.base   = 16'(fbase_q);
  assign push_desc.nwords = 16'(({4'd0, len_q} + 20'd3) >> 2);
  assign push_desc.tail   = 16'(ncell * 20'(PAY_WORDS) - 20'd2);

  always_comb begin
    wpos_d  = wpos_q;
    act_d   = act_q;
    last_d  = last_q;
    ovf_d   = ovf_q;
    idx_d   = idx_q;
    crc_d   = crc_q;
    len_d   = len_q;
    wptr_d  = wptr_q;
    fbase_d = fbase_q;
    errv_d  = 1'b0;
    errc_d  = errc_q;
    if (in_vld) begin
      wpos_d = (cur == 4'(CELL_WORDS - 1)) ? 4'd0 : cur + 4'd1;
      if (cur == 4'd0) begin
        last_d = in_data[LAST_BIT];
        if (!act_q) begin
          act_d   = 1'b1;
          idx_d   = '0;
          ovf_d   = 1'b0;
          crc_d   = CRC_SEED;
          fbase_d = wptr_q;
        end else if (!ovf_q) begin
          if (idx_q == IW'(MAX_CELLS - 1)) ovf_d = 1'b1;
          else                             idx_d = idx_q + 1'b1;
        end
      end
      if (wr_en) wptr_d = wptr_inc;
      if (is_pay && !ovf_q && !is_final) crc_d = crc_step(crc_q, in_data);
      if (last_q && cur == 4'(CELL_WORDS - 2)) len_d = in_data[15:0];
      if (is_final) begin
        act_d = 1'b0;
        ovf_d = 1'b0;
        if (verdict != ERR_NONE) begin
          errv_d = 1'b1;
          errc_d = verdict;
          wptr_d = fbase_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos_q  <= '0;
      act_q   <= 1'b0;
      last_q  <= 1'b0;
      ovf_q   <= 1'b0;
      idx_q   <= '0;
      crc_q   <= CRC_SEED;
      len_q   <= '0;
      wptr_q  <= '0;
      fbase_q <= '0;
      errv_q  <= 1'b0;
      errc_q  <= ERR_NONE;
    end else begin
      wpos_q  <= wpos_d;
      act_q   <= act_d;
      last_q  <= last_d;
      ovf_q   <= ovf_d;
      idx_q   <= idx_d;
      crc_q   <= crc_d;
      len_q   <= len_d;
      wptr_q  <= wptr_d;
      fbase_q <= fbase_d;
      errv_q  <= errv_d;
      errc_q  <= errc_d;
    end
  end

  assign err_vld  = errv_q;
  assign err_code = errc_q;

  // R7
  // rollback_chk: a dropped frame gives its ring space back
  rollback_chk: assert property (@(posedge clk) disable iff (!rst_n) errv_q |-> (wptr_q == fbase_q));

  // R9
  // err_pulse_chk
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) errv_q |=> !errv_q);

endmodule

// File: rtl/aal5_rx_emit.sv
module aal5_rx_emit
  import aal5_rx_pkg::*;
#(
  parameter int RING_WORDS = 192,
  parameter int AW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          empty,
  input  fdesc_t        head,
  output logic          pop,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic [31:0]   out_data,
  output logic          out_de,
  output logic          out_sof,
  output logic          out_eof,
  output logic          out_trl
);

  function automatic logic [AW-1:0] ring_add(input logic [15:0] a, input logic [15:0] b);
    int s;
    s = int'(a) + int'(b);
    if (s >= RING_WORDS) s = s - RING_WORDS;
    return AW'(s);
  endfunction

  logic [15:0] k_q, k_d;
  logic        busy, in_pay;
  logic [31:0] data_q, data_d;
  logic        de_q, de_d, sof_q, sof_d, eof_q, eof_d, trl_q, trl_d;

  assign busy   = !empty;
  assign in_pay = (k_q < head.nwords);
  assign pop    = busy && (k_q == head.nwords + 16'd1);

  always_comb begin
    if (in_pay)                  rd_addr = ring_add(head.base, k_q);
    else if (k_q == head.nwords) rd_addr = ring_add(head.base, head.tail);
    else                         rd_addr = ring_add(head.base, head.tail + 16'd1);
  end

  always_comb begin
    k_d    = k_q;
    data_d = '0;
    de_d   = 1'b0;
    sof_d  = 1'b0;
    eof_d  = 1'b0;
    trl_d  = 1'b0;
    if (busy) begin
      k_d    = pop ? 16'd0 : k_q + 16'd1;
      data_d = rd_data;
      de_d   = in_pay;
      sof_d  = (k_q == 16'd0);
      eof_d  = (k_q == head.nwords - 16'd1);
      trl_d  = !in_pay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= '0;
      data_q <= '0;
      de_q   <= 1'b0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      trl_q  <= 1'b0;
    end else begin
      k_q    <= k_d;
      data_q <= data_d;
      de_q   <= de_d;
      sof_q  <= sof_d;
      eof_q  <= eof_d;
      trl_q  <= trl_d;
    end
  end

  assign out_data = data_q;
  assign out_de   = de_q;
  assign out_sof  = sof_q;
  assign out_eof  = eof_q;
  assign out_trl  = trl_q;

  // R3
  // eof_de_chk
  eof_de_chk: assert property (@(posedge clk) disable iff (!rst_n) eof_q |-> de_q);

  // R4
  // trl_after_eof_chk
  trl_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n) eof_q |=> (trl_q && !de_q));

  // R2
  // de_cont_chk
  de_cont_chk: assert property (@(posedge clk) disable iff (!rst_n) (de_q && !sof_q) |-> $past(de_q));

endmodule

// File: rtl/aal5_rx_decap.sv
module aal5_rx_decap
  import aal5_rx_pkg::*;
#(
  parameter int MAX_CELLS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic        in_soc,
  input  logic [31:0] in_data,
  output logic [31:0] out_data,
  output logic        out_de,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_trl,
  output logic        err_vld,
  output logic [1:0]  err_code
);

  localparam int RING_WORDS = 2 * MAX_CELLS * PAY_WORDS;
  localparam int AW         = $clog2(RING_WORDS);
  localparam int QDEPTH     = (MAX_CELLS > 2) ? MAX_CELLS : 2;

  logic [1:0]    rsync_q;
  logic          rst_i_n;
  logic          wr_en, push, pop, q_empty, q_full;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  fdesc_t        push_desc, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  aal5_rx_ingest #(
    .MAX_CELLS (MAX_CELLS),
    .RING_WORDS(RING_WORDS),
    .AW        (AW),
    .LAST_BIT  (1)
  ) ingest_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .in_vld   (in_vld),
    .in_soc   (in_soc),
    .in_data  (in_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .push     (push),
    .push_desc(push_desc),
    .err_vld  (err_vld),
    .err_code (err_code)
  );

  aal5_rx_ring #(
    .WORDS(RING_WORDS),
    .AW   (AW)
  ) ring_i (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  aal5_rx_dfifo #(
    .DEPTH(QDEPTH)
  ) queue_i (
    .clk  (clk),
    .rst_n(rst_i_n),
    .push (push),
    .din  (push_desc),
    .pop  (pop),
    .dout (head),
    .empty(q_empty),
    .full (q_full)
  );

  aal5_rx_emit #(
    .RING_WORDS(RING_WORDS),
    .AW        (AW)
  ) emit_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .empty   (q_empty),
    .head    (head),
    .pop     (pop),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .out_data(out_data),
    .out_de  (out_de),
    .out_sof (out_sof),
    .out_eof (out_eof),
    .out_trl (out_trl)
  );

endmodule

// File: tb/aal5_rx_decap_tb_top.sv
module aal5_rx_decap_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        in_soc = 1'b0;
  logic [31:0] in_data = 32'h0;
  logic [31:0] out_data;
  logic        out_de, out_sof, out_eof, out_trl, err_vld;
  logic [1:0]  err_code;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  aal5_rx_decap #(.MAX_CELLS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_soc(in_soc), .in_data(in_data),
    .out_data(out_data), .out_de(out_de), .out_sof(out_sof), .out_eof(out_eof),
    .out_trl(out_trl), .err_vld(err_vld), .err_code(err_code)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc == 150000) begin
      failures++;
      $display("FAIL R9 watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // output recorder, sampled at the falling edge
  logic [31:0] obs_d [0:1023];
  logic [3:0]  obs_f [0:1023];
  int          obs_c [0:1023];
  int          on = 0;
  logic [1:0]  err_k [0:63];
  int          err_cy [0:63];
  int          en = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((out_de || out_trl) && on < 1024) begin
        obs_d[on] = out_data;
        obs_f[on] = {out_de, out_sof, out_eof, out_trl};
        obs_c[on] = cyc;
        on++;
      end
      if (err_vld && en < 64) begin
        err_k[en]  = err_code;
        err_cy[en] = cyc;
        en++;
      end
    end
  end

  logic [31:0] fw [0:127];
  int fn;
  int flen;
  int last_edge;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 4; b++) begin
      r = r ^ {w[31 - 8*b -: 8], 24'h0};
      for (int j = 0; j < 8; j++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    end
    return r;
  endfunction

  task automatic build(input int len, input int seed, input logic [15:0] ctl);
    logic [31:0] c;
    fn   = (len + 8 + 47) / 48;
    flen = len;
    for (int i = 0; i < 128; i++) fw[i] = 32'h0;
    for (int i = 0; i < len; i++) fw[i/4][31 - 8*(i%4) -: 8] = 8'((seed + i*7) & 255);
    fw[fn*12-2] = {ctl, 16'(len)};
    c = 32'hFFFFFFFF;
    for (int i = 0; i < fn*12-1; i++) c = ref_crc(c, fw[i]);
    fw[fn*12-1] = ~c;
  endtask

  task automatic put(input logic soc, input logic [31:0] d, input int gap);
    @(negedge clk);
    in_vld = 1'b1; in_soc = soc; in_data = d;
    last_edge = cyc + 1;
    if (gap != 0) begin
      @(negedge clk);
      in_vld = 1'b0; in_soc = 1'b0;
    end
  endtask

  // R5: header word 0 bit 1 marks the last cell
  task automatic send(input int gap, input int skip);
    for (int c = 0; c < fn; c++) begin
      if (c == skip) continue;
      put(1'b1, 32'h01234560 | ((c == fn-1) ? 32'h2 : 32'h0), gap);
      put(1'b0, 32'h0, gap);
      for (int p = 0; p < 12; p++) put(1'b0, fw[c*12+p], gap);
    end
    @(negedge clk);
    in_vld = 1'b0; in_soc = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_frame(input int s, input string req);
    int p;
    p = (flen + 3) / 4;
    chk(on - s >= p + 2, req, "delivered word count", 64'(on - s), 64'(p + 2));
    if (on - s >= p + 2) begin
      for (int i = 0; i < p + 2; i++) begin
        logic [31:0] ed;
        logic [3:0]  ef;
        ed = (i < p) ? fw[i] : fw[fn*12-2 + (i-p)];
        ef = {i < p, i == 0, i == p-1, i >= p};
        chk(obs_d[s+i] == ed && obs_f[s+i] == ef, req, "word/flags",
            {28'h0, obs_f[s+i], obs_d[s+i]}, {28'h0, ef, ed});
      end
    end
  endtask

  task automatic t_reset;
    chk({out_de, out_sof, out_eof, out_trl, err_vld} == 5'b0, "R1", "strobes after reset",
        64'({out_de, out_sof, out_eof, out_trl, err_vld}), 64'h0);
  endtask

  task automatic t_single;
    int s, e;
    s = on; e = en;
    build(5, 3, 16'hA55A);
    send(0, -1);
    settle(40);
    chk(on - s == 4, "R2", "single-cell word count", 64'(on - s), 64'd4);
    check_frame(s, "R2 R3 R4");
    chk(obs_c[s] == last_edge + 1, "R9", "sof latency", 64'(obs_c[s]), 64'(last_edge + 1));
    chk(en == e, "R6", "no error on good frame", 64'(en - e), 64'd0);
  endtask

  task automatic t_gaps;
    int s;
    s = on;
    build(130, 11, 16'h0102);
    send(1, -1);
    settle(120);
    chk(on - s == 35, "R11", "gapped three-cell count", 64'(on - s), 64'd35);
    check_frame(s, "R5 R11");
  endtask

  task automatic t_padding;
    int s;
    s = on;
    build(40, 17, 16'h1111);
    send(0, -1);
    settle(40);
    check_frame(s, "R2 exact fill");
    s = on;
    build(41, 29, 16'h2222);
    send(0, -1);
    settle(60);
    chk(on - s == 13, "R2", "padding suppressed count", 64'(on - s), 64'd13);
    check_frame(s, "R2 R3 padded");
  endtask

  task automatic t_crc_err;
    int s, e;
    s = on; e = en;
    build(24, 7, 16'h3333);
    fw[fn*12-1] = fw[fn*12-1] ^ 32'h1;
    send(0, -1);
    settle(30);
    chk(en == e + 1 && err_k[e] == 2'd1, "R6", "crc error code", 64'(err_k[e]), 64'd1);
    chk(err_cy[e] == last_edge, "R9", "error pulse cycle", 64'(err_cy[e]), 64'(last_edge));
    chk(on == s, "R6", "dropped frame output", 64'(on - s), 64'd0);
  endtask

  task automatic t_len_err;
    int s, e;
    s = on; e = en;
    build(60, 9, 16'h4444);
    fw[22][15:0] = 16'd4;
    send(0, -1);
    settle(30);
    chk(en == e + 1 && err_k[e] == 2'd2, "R7", "short length code", 64'(err_k[e]), 64'd2);
    build(60, 9, 16'h4444);
    send(0, 0);
    settle(30);
    chk(en == e + 2 && err_k[e+1] == 2'd2, "R7", "lost cell code", 64'(err_k[e+1]), 64'd2);
    chk(on == s, "R7", "dropped frame output", 64'(on - s), 64'd0);
  endtask

  task automatic t_long;
    int s, e;
    s = on; e = en;
    build(424, 13, 16'h5555);
    send(0, -1);
    settle(30);
    chk(en == e + 1 && err_k[e] == 2'd3, "R8", "too many cells code", 64'(err_k[e]), 64'd3);
    chk(on == s, "R8", "aborted frame output", 64'(on - s), 64'd0);
    build(20, 31, 16'h6666);
    send(0, -1);
    settle(40);
    check_frame(s, "R8 recovery");
  endtask

  task automatic t_queue;
    int s, t;
    s = on;
    build(130, 21, 16'h7777);
    send(0, -1);
    build(8, 5, 16'h8888);
    send(0, -1);
    t = last_edge;
    settle(80);
    chk(on - s == 39, "R10", "queued total count", 64'(on - s), 64'd39);
    check_frame(s + 35, "R10 second frame");
    chk(obs_c[s+35] == obs_c[s+34] + 1, "R10", "no gap between frames",
        64'(obs_c[s+35]), 64'(obs_c[s+34] + 1));
    chk(obs_c[s+35] > t + 1, "R10", "second frame was held", 64'(obs_c[s+35]), 64'(t + 2));
    build(130, 21, 16'h7777);
    check_frame(s, "R10 first frame");
  endtask

  initial begin
    settle(5);
    t_reset;
    rst_n = 1'b1;
    settle(5);
    t_reset;
    t_single;
    t_gaps;
    t_padding;
    t_crc_err;
    t_len_err;
    t_long;
    t_queue;
    settle(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule